// File: doc/BRIEF.md
# SDRAM Request Splitter and Address Decoder

This block sits between an application port and an SDRAM bank controller. It takes a transfer request that names a linear word address, a length, a direction and a wrap flag. It then turns that request into one or more sub-requests, each already decoded into bank, row and starting column. The width of the column field is chosen at run time from four settings, so the same block serves devices with different page sizes.

A request without wrap is cut wherever it would run past the end of a page (row). Each piece carries its own length and starting column. The first piece is marked as start and the final piece as last. A request with wrap is forwarded whole as a single fixed-length burst that stays inside its page. Every piece waits on a valid/acknowledge handshake with the bank controller. The application gets one acknowledge pulse once the final piece has been taken. An active-low busy output tells the application when it may present the next request, and no request is taken before the memory reports that its initialisation is done.

Top module: `sdram_req_splitter`

## Requirements
- R1: While `init_done` is low, `busy_n` is low and no request is accepted, so `sub_valid` stays low even with `req_valid` held high.
- R2: `col_sel` sets the column field width: 0 gives 8 bits, 1 gives 9, 2 gives 10 and 3 gives 11. `sub_col` is the low field of the current address, zero-extended to 12 bits.
- R3: `sub_bank` is the 2 address bits directly above the column field. `sub_row` is the 12 address bits directly above the bank bits.
- R4: A request without wrap is split so that no piece crosses a page boundary. Each piece length is the smaller of the words remaining and the words left in the current page. Each next piece starts where the previous one ended, and the lengths add up to `req_len` (which is 1 or more).
- R5: `sub_start` is high on the first piece of a request only. `sub_last` is high on the final piece only.
- R6: A request with wrap produces exactly one piece, with `sub_len` equal to 4 whatever `req_len` says, both markers high, `sub_wrap` high and the column of the request address.
- R7: While `sub_valid` is high and `sub_ack` is low, `sub_valid` and every sub-request field hold their values.
- R8: `req_ack` is a one-cycle pulse in the cycle after the clock edge on which the final piece was acknowledged. It is never high at any other time.
- R9: A request is accepted on a clock edge where `req_valid` and `busy_n` are both high. `busy_n` is low from that edge through the `req_ack` cycle and high again in the cycle after.
- R10: `sub_write` on every piece equals the `req_write` value that was captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | Memory initialisation complete |
| col_sel | input | 2 | Column width select (0..3 gives 8..11 bits); held static while busy |
| req_valid | input | 1 | Application request present |
| req_addr | input | ADDR_W | Linear word address |
| req_len | input | LEN_W | Transfer length in words |
| req_wrap | input | 1 | Wrap (fixed burst) mode |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ack | output | 1 | Whole request taken downstream |
| busy_n | output | 1 | Low while busy; high when a request may be presented |
| sub_valid | output | 1 | Sub-request valid |
| sub_ack | input | 1 | Bank controller takes the sub-request |
| sub_start | output | 1 | First piece of a request |
| sub_last | output | 1 | Final piece of a request |
| sub_wrap | output | 1 | Piece is a wrap burst |
| sub_write | output | 1 | Piece direction |
| sub_bank | output | BANK_W | Decoded bank |
| sub_row | output | ROW_W | Decoded row |
| sub_col | output | COL_OUT_W | Decoded starting column |
| sub_len | output | LEN_W | Piece length in words |

## Verification
A wrong running address or remaining count shows up at the ports on the very next piece. It appears as a wrong column, bank or row, as a piece that runs past the page end, or as lengths that do not add up to the request. A stuck or skipped state in the sequencer shows up within one cycle of the last handshake: `req_ack` is missing or early, or `busy_n` fails to return high. The bench pays back acknowledges at random delays, so a field that changes while the handshake is stalled is caught at the cycle where the change happens.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
   // narrowest selectable column field and number of selectable widths
   localparam int COL_MIN  = 8;
   localparam int COL_OPTS = 4;
   localparam int SEL_W    = 2;
   localparam int ROOM_W   = COL_MIN + COL_OPTS;   // holds a full page size

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DONE  = 2'd2
   } sreq_state_e;
endpackage

// File: rtl/sreq_decode.sv
module sreq_decode
   import sreq_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12,
   parameter int COL_OUT_W = 12
)(
   input  logic [ADDR_W-1:0]    addr,
   input  logic [SEL_W-1:0]     col_sel,
   output logic [BANK_W-1:0]    bank,
   output logic [ROW_W-1:0]     row,
   output logic [COL_OUT_W-1:0] col,
   output logic [ROOM_W-1:0]    room
);
   localparam int COL_MAX = COL_MIN + COL_OPTS - 1;

   if (COL_MAX + BANK_W + ROW_W > ADDR_W) begin : g_bad_addr
      $error("sreq_decode: ADDR_W too small for widest column + bank + row");
   end
   if (COL_MAX > COL_OUT_W) begin : g_bad_col
      $error("sreq_decode: COL_OUT_W narrower than widest column field");
   end
   if ((1 << SEL_W) != COL_OPTS) begin : g_bad_sel
      $error("sreq_decode: COL_OPTS must fill the select range");
   end

   logic [BANK_W-1:0]    bank_c [COL_OPTS];
   logic [ROW_W-1:0]     row_c  [COL_OPTS];
   logic [COL_OUT_W-1:0] col_c  [COL_OPTS];
   logic [ROOM_W-1:0]    room_c [COL_OPTS];

   // one decode slice per selectable column width
   for (genvar g = 0; g < COL_OPTS; g++) begin : g_width
      localparam int CB = COL_MIN + g;
      assign col_c[g]  = COL_OUT_W'(addr[CB-1:0]);
      assign bank_c[g] = addr[CB +: BANK_W];
      assign row_c[g]  = addr[CB+BANK_W +: ROW_W];
      assign room_c[g] = ROOM_W'(1 << CB) - ROOM_W'(addr[CB-1:0]);
   end

   assign bank = bank_c[col_sel];
   assign row  = row_c[col_sel];
   assign col  = col_c[col_sel];
   assign room = room_c[col_sel];
endmodule

// File: rtl/sreq_chunk.sv
module sreq_chunk
   import sreq_pkg::*;
#(
   parameter int LEN_W    = 9,
   parameter int WRAP_LEN = 4
)(
   input  logic [LEN_W-1:0]  rem,
   input  logic [ROOM_W-1:0] room,
   input  logic              wrap,
   output logic [LEN_W-1:0]  len,
   output logic              last
);
   localparam int CMP_W = (LEN_W > ROOM_W) ? LEN_W : ROOM_W;

   if (WRAP_LEN >= (1 << LEN_W)) begin : g_bad_wrap
      $error("sreq_chunk: WRAP_LEN does not fit LEN_W");
   end

   logic [CMP_W-1:0] rem_x, room_x;
   logic             fits;

   assign rem_x  = CMP_W'(rem);
   assign room_x = CMP_W'(room);
   assign fits   = (rem_x <= room_x);

   always_comb begin
      if (wrap) begin
         len  = LEN_W'(WRAP_LEN);
         last = 1'b1;
      end else if (fits) begin
         len  = rem;
         last = 1'b1;
      end else begin
         // room < rem here, so room fits in LEN_W
         len  = LEN_W'(room_x);
         last = 1'b0;
      end
   end
endmodule

// File: rtl/sreq_ctrl.sv
module sreq_ctrl
   import sreq_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int LEN_W  = 9
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_done,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_wrap,
   input  logic              req_write,
   input  logic              sub_ack,
   input  logic [LEN_W-1:0]  piece_len,
   input  logic              piece_last,
   output logic              busy_n,
   output logic              req_ack,
   output logic              sub_valid,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LEN_W-1:0]  cur_rem,
   output logic              cur_wrap,
   output logic              cur_write,
   output logic              cur_first
);
   sreq_state_e state;
   logic        accept;

   assign busy_n    = init_done && (state == ST_IDLE);
   assign accept    = req_valid && busy_n;
   assign sub_valid = (state == ST_ISSUE);
   assign req_ack   = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_addr  <= '0;
         cur_rem   <= '0;
         cur_wrap  <= 1'b0;
         cur_write <= 1'b0;
         cur_first <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  cur_addr  <= req_addr;
                  cur_rem   <= req_len;
                  cur_wrap  <= req_wrap;
                  cur_write <= req_write;
                  cur_first <= 1'b1;
                  state     <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (sub_ack) begin
                  cur_first <= 1'b0;
                  if (piece_last) begin
                     state <= ST_DONE;
                  end else begin
                     cur_addr <= cur_addr + ADDR_W'(piece_len);
                     cur_rem  <= cur_rem - piece_len;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdram_req_splitter.sv
module sdram_req_splitter
   import sreq_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int LEN_W     = 9,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12,
   parameter int COL_OUT_W = 12,
   parameter int WRAP_LEN  = 4
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init_done,
   input  logic [SEL_W-1:0]     col_sel,
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [LEN_W-1:0]     req_len,
   input  logic                 req_wrap,
   input  logic                 req_write,
   output logic                 req_ack,
   output logic                 busy_n,
   output logic                 sub_valid,
   input  logic                 sub_ack,
   output logic                 sub_start,
   output logic                 sub_last,
   output logic                 sub_wrap,
   output logic                 sub_write,
   output logic [BANK_W-1:0]    sub_bank,
   output logic [ROW_W-1:0]     sub_row,
   output logic [COL_OUT_W-1:0] sub_col,
   output logic [LEN_W-1:0]     sub_len
);
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  cur_rem;
   logic              cur_wrap, cur_write, cur_first;
   logic [ROOM_W-1:0] room;
   logic [LEN_W-1:0]  piece_len;
   logic              piece_last;

   sreq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_done  (init_done),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .req_wrap   (req_wrap),
      .req_write  (req_write),
      .sub_ack    (sub_ack),
      .piece_len  (piece_len),
      .piece_last (piece_last),
      .busy_n     (busy_n),
      .req_ack    (req_ack),
      .sub_valid  (sub_valid),
      .cur_addr   (cur_addr),
      .cur_rem    (cur_rem),
      .cur_wrap   (cur_wrap),
      .cur_write  (cur_write),
      .cur_first  (cur_first)
   );

   sreq_decode #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_OUT_W(COL_OUT_W)
   ) u_decode (
      .addr    (cur_addr),
      .col_sel (col_sel),
      .bank    (sub_bank),
      .row     (sub_row),
      .col     (sub_col),
      .room    (room)
   );

   sreq_chunk #(.LEN_W(LEN_W), .WRAP_LEN(WRAP_LEN)) u_chunk (
      .rem  (cur_rem),
      .room (room),
      .wrap (cur_wrap),
      .len  (piece_len),
      .last (piece_last)
   );

   assign sub_len   = piece_len;
   assign sub_start = sub_valid && cur_first;
   assign sub_last  = sub_valid && piece_last;
   assign sub_wrap  = cur_wrap;
   assign sub_write = cur_write;
endmodule

// File: rtl/sreq_checker.sv
module sreq_checker
   import sreq_pkg::*;
#(
   parameter int LEN_W     = 9,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12,
   parameter int COL_OUT_W = 12,
   parameter int WRAP_LEN  = 4
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 init_done,
   input logic [SEL_W-1:0]     col_sel,
   input logic                 req_ack,
   input logic                 busy_n,
   input logic                 sub_valid,
   input logic                 sub_ack,
   input logic                 sub_start,
   input logic                 sub_last,
   input logic                 sub_wrap,
   input logic                 sub_write,
   input logic [BANK_W-1:0]    sub_bank,
   input logic [ROW_W-1:0]     sub_row,
   input logic [COL_OUT_W-1:0] sub_col,
   input logic [LEN_W-1:0]     sub_len
);
   localparam int PG_W = ROOM_W + 1;

   logic [PG_W-1:0] page_sz, span_end;
   always_comb begin
      page_sz  = PG_W'(1) << (COL_MIN + 32'(col_sel));
      span_end = PG_W'(sub_col) + PG_W'(sub_len);
   end

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_done && !sub_valid) |=> !sub_valid)
      else $error("sub-request issued before init done");

   assert_no_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && !sub_wrap) |-> (span_end <= page_sz && sub_len != '0))
      else $error("piece crosses page end");

   assert_wrap_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && sub_wrap) |-> (sub_len == LEN_W'(WRAP_LEN) && sub_start && sub_last))
      else $error("wrap piece malformed");

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid && !sub_ack) |=> (sub_valid && $stable(sub_bank) && $stable(sub_row)
                                   && $stable(sub_col) && $stable(sub_len)
                                   && $stable(sub_start) && $stable(sub_last)
                                   && $stable(sub_write) && $stable(sub_wrap)))
      else $error("sub-request changed while stalled");

   assert_ack_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> $past(sub_valid && sub_ack && sub_last))
      else $error("application ack without final handshake");

   assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack)
      else $error("application ack longer than one cycle");

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_valid || req_ack) |-> !busy_n)
      else $error("ready reported during a transfer");
endmodule

bind sdram_req_splitter sreq_checker #(
   .LEN_W(LEN_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
   .COL_OUT_W(COL_OUT_W), .WRAP_LEN(WRAP_LEN)
) u_sreq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .init_done (init_done),
   .col_sel   (col_sel),
   .req_ack   (req_ack),
   .busy_n    (busy_n),
   .sub_valid (sub_valid),
   .sub_ack   (sub_ack),
   .sub_start (sub_start),
   .sub_last  (sub_last),
   .sub_wrap  (sub_wrap),
   .sub_write (sub_write),
   .sub_bank  (sub_bank),
   .sub_row   (sub_row),
   .sub_col   (sub_col),
   .sub_len   (sub_len)
);

// File: tb/test_sdram_req_splitter.sv
`timescale 1ns/1ps
module test_sdram_req_splitter;
   localparam int ADDR_W = 26;
   localparam int LEN_W  = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              init_done = 1'b0;
   logic [1:0]        col_sel = 2'd0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [LEN_W-1:0]  req_len = '0;
   logic              req_wrap = 1'b0;
   logic              req_write = 1'b0;
   logic              sub_ack = 1'b0;
   logic              req_ack, busy_n, sub_valid, sub_start, sub_last;
   logic              sub_wrap, sub_write;
   logic [1:0]        sub_bank;
   logic [11:0]       sub_row, sub_col;
   logic [LEN_W-1:0]  sub_len;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   sdram_req_splitter i_sdram_req_splitter (
      .clk(clk), .rst_n(rst_n), .init_done(init_done), .col_sel(col_sel),
      .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
      .req_wrap(req_wrap), .req_write(req_write), .req_ack(req_ack),
      .busy_n(busy_n), .sub_valid(sub_valid), .sub_ack(sub_ack),
      .sub_start(sub_start), .sub_last(sub_last), .sub_wrap(sub_wrap),
      .sub_write(sub_write), .sub_bank(sub_bank), .sub_row(sub_row),
      .sub_col(sub_col), .sub_len(sub_len)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int page_words(input int cs);
      return 1 << (8 + cs);
   endfunction

   function automatic int piece_len(input int a, input int rem, input int cs, input bit wrap);
      int room;
      room = page_words(cs) - (a % page_words(cs));
      if (wrap) return 4;
      return (rem <= room) ? rem : room;
   endfunction

   task automatic run_req(input int addr, input int len, input bit wrap,
                          input bit wr, input int cs);
      int  ea, er, cyc, cb, elen;
      bit  first, done, ack_due, elast;
      ea = addr; er = len; cyc = 0; first = 1; done = 0; ack_due = 0;
      cb = 8 + cs;
      @(negedge clk);
      col_sel = 2'(cs); req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
      req_wrap = wrap; req_write = wr; req_valid = 1'b1;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (ack_due) begin
            check(req_ack == 1'b1, "R8 ack after final piece", int'(req_ack), 1);
            req_valid = 1'b0;
            sub_ack = 1'b0;
            done = 1;
         end else begin
            if (req_ack) check(1'b0, "R8 early ack", 1, 0);
            if (sub_valid) begin
               if (busy_n) check(1'b0, "R9 busy during transfer", 1, 0);
               if ($urandom_range(0, 2) != 0) begin
                  elen  = piece_len(ea, er, cs, wrap);
                  elast = wrap || (er <= page_words(cs) - (ea % page_words(cs)));
                  check(int'(sub_col) == ea % page_words(cs), "R2 column",
                        int'(sub_col), ea % page_words(cs));
                  check(int'(sub_bank) == ((ea >> cb) & 3), "R3 bank",
                        int'(sub_bank), (ea >> cb) & 3);
                  check(int'(sub_row) == ((ea >> (cb + 2)) & 12'hFFF), "R3 row",
                        int'(sub_row), (ea >> (cb + 2)) & 12'hFFF);
                  if (wrap)
                     check(int'(sub_len) == 4, "R6 wrap length", int'(sub_len), 4);
                  else
                     check(int'(sub_len) == elen, "R4 piece length", int'(sub_len), elen);
                  check(sub_start == first, "R5 start marker", int'(sub_start), int'(first));
                  check(sub_last == elast, "R5 last marker", int'(sub_last), int'(elast));
                  check(sub_write == wr, "R10 direction", int'(sub_write), int'(wr));
                  check(sub_wrap == wrap, "R6 wrap flag", int'(sub_wrap), int'(wrap));
                  sub_ack = 1'b1;
                  ea = (ea + elen) & ((1 << ADDR_W) - 1);
                  er = er - elen;
                  first = 0;
                  if (elast) ack_due = 1;
               end else begin
                  sub_ack = 1'b0;
               end
            end else begin
               sub_ack = 1'b0;
            end
         end
      end
      if (!done) begin
         check(1'b0, "R8 request never acknowledged", 0, 1);
         req_valid = 1'b0;
         sub_ack = 1'b0;
      end else begin
         if (!wrap) check(er == 0, "R4 lengths sum", len - er, len);
         @(negedge clk);
         check(busy_n == 1'b1, "R9 ready after ack", int'(busy_n), 1);
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int a, l, cs;
      bit w;
      void'($urandom(32'h5A17C3));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_n == 1'b0, "R1 busy before init", int'(busy_n), 0);
      check(sub_valid == 1'b0, "R1 idle after reset", int'(sub_valid), 0);
      check(req_ack == 1'b0, "R8 no ack after reset", int'(req_ack), 0);
      // request held while init is low must not be taken
      req_valid = 1'b1; req_addr = 26'h123; req_len = 9'd8;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check(sub_valid == 1'b0, "R1 no issue before init", int'(sub_valid), 0);
      end
      req_valid = 1'b0;
      init_done = 1'b1;
      @(negedge clk);
      check(busy_n == 1'b1, "R9 ready once init done", int'(busy_n), 1);

      // directed corners
      run_req(32'h0F0, 32, 1'b0, 1'b1, 0);   // R4 two pieces of 16
      run_req(32'h0FF, 300, 1'b0, 1'b0, 0);  // R4 1 + 256 + 43
      run_req(32'h1FF, 1, 1'b0, 1'b1, 1);    // R5 exactly fills page
      run_req(32'h000, 511, 1'b0, 1'b0, 3);  // R2 widest column, one piece
      run_req(32'h3FE, 100, 1'b1, 1'b1, 2);  // R6 wrap ignores length
      run_req(32'h3FFFFFF, 3, 1'b0, 1'b0, 2);// R4 address space top
      run_req(32'h2C3F80, 200, 1'b0, 1'b1, 1); // R3 bank/row bits

      // constrained random
      for (int k = 0; k < 60; k++) begin
         cs = $urandom_range(0, 3);
         a  = $urandom & ((1 << ADDR_W) - 1);
         if ($urandom_range(0, 3) == 0)
            a = (a | (page_words(cs) - 1)) - $urandom_range(0, 7);
         l  = $urandom_range(1, 511);
         w  = ($urandom_range(0, 4) == 0);
         run_req(a, l, w, 1'($urandom_range(0, 1)), cs);
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule